// File: doc/BRIEF.md
# UART with RTS/CTS Flow Control

A full-duplex asynchronous serial port that links a host to an embedded module. The transmit side takes one character at a time over a valid/ready handshake, frames it with a start bit, 8 or 9 data bits sent LSB first, an optional parity bit and one stop bit, and sends it on `txd_o`. The receive side oversamples `rxd_i` at 16 ticks per bit, confirms the start bit at its midpoint, and places each completed character in a single holding register with its parity and framing status.

Flow control works at character granularity. With receive flow control on, the active-low request-to-send output follows the holding register directly: it goes high when a character lands and low once the consumer reads it, so the peer stops at a frame boundary. With transmit flow control on, the synchronised active-low clear-to-send input is looked at only when an idle transmitter decides whether to start a frame, so a frame that has begun always completes. Baud divisor, data length, parity mode and both enables are run-time inputs.

Top module: `uart_fc`

## Requirements
- R1: A frame on `txd_o` is a 0 start bit, the data bits LSB first (8 when `nine_bit_i`=0, 9 when 1), the parity bit if enabled, then a single 1 stop bit; each bit lasts 16*(`baud_div_i`+1) clock cycles and `txd_o` rests at 1 when idle.
- R2: `parity_i` encodes 0 none, 1 even, 2 odd, 3 none; the even parity bit is the XOR of the data bits in use and the odd parity bit is its inverse.
- R3: `tx_ready_o` is high only while the transmitter is idle; after a cycle with `tx_valid_i` and `tx_ready_o` both high, `txd_o` drives the start bit from the next cycle.
- R4: With `cts_en_i`=1 a frame starts only when `cts_ni`, seen through a two-stage synchroniser, is 0; raising `cts_ni` during a frame never shortens it; with `cts_en_i`=0 `cts_ni` has no effect.
- R5: The receiver accepts a start bit only if `rxd_i` is still 0 at the middle of the start bit; a shorter low pulse produces no character. A received character sets `rx_valid_o` and appears on `rx_data_o` (upper bit 0 in 8-bit mode).
- R6: While `rx_valid_o` is 1 and `rx_read_i` is 0, `rx_data_o` and the flags hold; a cycle with `rx_read_i`=1 clears `rx_valid_o` from the next cycle.
- R7: With `rts_en_i`=1, `rts_no` is 1 exactly while the holding register is full; with `rts_en_i`=0 it stays 0.
- R8: A character that completes while the holding register is full and not being read is dropped, the held character is kept, and `rx_overrun_o` goes to 1 and stays 1 until reset.
- R9: `rx_perr_o` is 1 for a held character whose received parity bit differs from the parity computed per R2, and 0 otherwise.
- R10: `rx_ferr_o` is 1 for a held character whose stop bit was sampled as 0; the character is still delivered.
- R11: With `txd_o` looped to `rxd_i`, `rts_no` looped to `cts_ni` and both enables on, a consumer much slower than the line receives every character in order with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_div_i | input | 16 | Oversampling tick every baud_div_i+1 clocks |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| parity_i | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| rts_en_i | input | 1 | Receive flow control enable |
| cts_en_i | input | 1 | Transmit flow control enable |
| tx_data_i | input | 9 | Character to send |
| tx_valid_i | input | 1 | Character offered |
| tx_ready_o | output | 1 | Transmitter takes the character this cycle |
| txd_o | output | 1 | Serial output |
| cts_ni | input | 1 | Clear-to-send, active low |
| rxd_i | input | 1 | Serial input |
| rx_data_o | output | 9 | Held character |
| rx_valid_o | output | 1 | Holding register not empty |
| rx_read_i | input | 1 | Consume the held character |
| rx_perr_o | output | 1 | Parity error of held character |
| rx_ferr_o | output | 1 | Framing error of held character |
| rx_overrun_o | output | 1 | Sticky overrun flag |
| rts_no | output | 1 | Request-to-send, active low |

## Verification
The start bit appears on `txd_o` one cycle after the handshake and every later bit 16*(`baud_div_i`+1) cycles on, so the bench finds the falling edge and then samples each bit at its middle, half a bit period in and one period apart. A received character is registered two cycles after the receiver samples the stop bit, and the bench checks the holding register ten cycles after its own mid-stop sample, then checks `rx_valid_o` one cycle after a read. The clear-to-send path has two synchroniser stages plus the start decision, so stall and release checks wait hundreds of cycles rather than relying on edge-exact timing, while `rts_no` is checked in the same cycle as the holding register because it is a direct function of it.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int unsigned DATA_MAX = 9;
  localparam int unsigned IDX_W    = $clog2(DATA_MAX);
  localparam int unsigned OVS      = 16;
  localparam int unsigned OVS_W    = $clog2(OVS);

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSVD = 2'd3
  } parity_e;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } frame_st_e;

  function automatic logic par_on(input parity_e p);
    return (p == PAR_EVEN) || (p == PAR_ODD);
  endfunction

  function automatic logic [DATA_MAX-1:0] data_mask(input logic nine);
    logic [DATA_MAX-1:0] m;
    m = '1;
    if (!nine) m[DATA_MAX-1] = 1'b0;
    return m;
  endfunction

  function automatic logic par_calc(input logic [DATA_MAX-1:0] d, input logic nine,
                                    input parity_e p);
    return (^(d & data_mask(nine))) ^ (p == PAR_ODD);
  endfunction

  function automatic logic [IDX_W-1:0] last_idx(input logic nine);
    return nine ? IDX_W'(DATA_MAX - 1) : IDX_W'(DATA_MAX - 2);
  endfunction
endpackage

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/uart_fc_baud.sv
module uart_fc_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  assign tick_o = (cnt == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                nine_bit_i,
  input  parity_e             parity_i,
  input  logic                cts_en_i,
  input  logic                cts_sync_i,
  input  logic [DATA_MAX-1:0] data_i,
  input  logic                valid_i,
  output logic                ready_o,
  output logic                txd_o
);
  localparam logic [OVS_W-1:0] TC_LAST = OVS_W'(OVS - 1);

  frame_st_e           st;
  logic [OVS_W-1:0]    tcnt;
  logic [IDX_W-1:0]    idx;
  logic [DATA_MAX-1:0] sh;
  logic                pbit;
  logic                accept;

  // CTS is consulted only at the idle-to-start decision
  assign ready_o = (st == FR_IDLE) && (!cts_en_i || !cts_sync_i);
  assign accept  = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st   <= FR_IDLE;
      tcnt <= '0;
      idx  <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else if (accept) begin
      st   <= FR_START;
      tcnt <= '0;
      idx  <= '0;
      sh   <= data_i;
      pbit <= par_calc(data_i, nine_bit_i, parity_i);
    end else if (tick_i && st != FR_IDLE) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == TC_LAST) begin
        unique case (st)
          FR_START: st <= FR_DATA;
          FR_DATA: begin
            if (idx == last_idx(nine_bit_i)) st <= par_on(parity_i) ? FR_PAR : FR_STOP;
            else idx <= idx + 1'b1;
          end
          FR_PAR:  st <= FR_STOP;
          FR_STOP: st <= FR_IDLE;
          default: st <= FR_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st)
      FR_START: txd_o = 1'b0;
      FR_DATA:  txd_o = sh[idx];
      FR_PAR:   txd_o = pbit;
      default:  txd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rxd_s_i,
  input  logic                nine_bit_i,
  input  parity_e             parity_i,
  input  logic                read_i,
  output logic [DATA_MAX-1:0] data_o,
  output logic                valid_o,
  output logic                perr_o,
  output logic                ferr_o,
  output logic                overrun_o
);
  localparam logic [OVS_W-1:0] TC_LAST = OVS_W'(OVS - 1);
  localparam logic [OVS_W-1:0] TC_MID  = OVS_W'(OVS / 2 - 1);

  frame_st_e           st;
  logic [OVS_W-1:0]    tcnt;
  logic [IDX_W-1:0]    idx;
  logic [DATA_MAX-1:0] sh;
  logic                pbit;
  logic                done_q;
  logic                stop_q;
  logic                par_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= FR_IDLE;
      tcnt     <= '0;
      idx      <= '0;
      sh       <= '0;
      pbit     <= 1'b0;
      done_q   <= 1'b0;
      stop_q   <= 1'b1;
      par_en_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == FR_IDLE) begin
        if (!rxd_s_i) begin
          st   <= FR_START;
          tcnt <= '0;
        end
      end else if (tick_i) begin
        tcnt <= tcnt + 1'b1;
        unique case (st)
          FR_START: begin
            if (tcnt == TC_MID) begin
              tcnt <= '0;
              idx  <= '0;
              sh   <= '0;
              st   <= rxd_s_i ? FR_IDLE : FR_DATA;
            end
          end
          FR_DATA: begin
            if (tcnt == TC_LAST) begin
              sh[idx] <= rxd_s_i;
              if (idx == last_idx(nine_bit_i)) st <= par_on(parity_i) ? FR_PAR : FR_STOP;
              else idx <= idx + 1'b1;
            end
          end
          FR_PAR: begin
            if (tcnt == TC_LAST) begin
              pbit <= rxd_s_i;
              st   <= FR_STOP;
            end
          end
          FR_STOP: begin
            if (tcnt == TC_LAST) begin
              stop_q   <= rxd_s_i;
              done_q   <= 1'b1;
              par_en_q <= par_on(parity_i);
              st       <= FR_IDLE;
            end
          end
          default: st <= FR_IDLE;
        endcase
      end
    end
  end

  // single holding register; a read in the same cycle frees it for the new character
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      data_o    <= '0;
      perr_o    <= 1'b0;
      ferr_o    <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (read_i && valid_o) valid_o <= 1'b0;
      if (done_q) begin
        if (valid_o && !read_i) begin
          overrun_o <= 1'b1;
        end else begin
          valid_o <= 1'b1;
          data_o  <= sh & data_mask(nine_bit_i);
          perr_o  <= par_en_q && (pbit != par_calc(sh, nine_bit_i, parity_i));
          ferr_o  <= !stop_q;
        end
      end
    end
  end
endmodule

// File: rtl/uart_fc.sv
module uart_fc
  import uart_fc_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DIV_W-1:0]    baud_div_i,
  input  logic                nine_bit_i,
  input  logic [1:0]          parity_i,
  input  logic                rts_en_i,
  input  logic                cts_en_i,
  input  logic [DATA_MAX-1:0] tx_data_i,
  input  logic                tx_valid_i,
  output logic                tx_ready_o,
  output logic                txd_o,
  input  logic                cts_ni,
  input  logic                rxd_i,
  output logic [DATA_MAX-1:0] rx_data_o,
  output logic                rx_valid_o,
  input  logic                rx_read_i,
  output logic                rx_perr_o,
  output logic                rx_ferr_o,
  output logic                rx_overrun_o,
  output logic                rts_no
);
  logic    tick;
  logic    cts_s;
  logic    rxd_s;
  parity_e par_mode;

  assign par_mode = parity_e'(parity_i);

  uart_fc_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (baud_div_i),
    .tick_o (tick)
  );

  uart_fc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_cts_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cts_ni),
    .q_o    (cts_s)
  );

  uart_fc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_rxd_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (rxd_s)
  );

  uart_fc_tx u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .nine_bit_i (nine_bit_i),
    .parity_i   (par_mode),
    .cts_en_i   (cts_en_i),
    .cts_sync_i (cts_s),
    .data_i     (tx_data_i),
    .valid_i    (tx_valid_i),
    .ready_o    (tx_ready_o),
    .txd_o      (txd_o)
  );

  uart_fc_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .rxd_s_i    (rxd_s),
    .nine_bit_i (nine_bit_i),
    .parity_i   (par_mode),
    .read_i     (rx_read_i),
    .data_o     (rx_data_o),
    .valid_o    (rx_valid_o),
    .perr_o     (rx_perr_o),
    .ferr_o     (rx_ferr_o),
    .overrun_o  (rx_overrun_o)
  );

  // peer is throttled straight from holding-register occupancy
  assign rts_no = rts_en_i & rx_valid_o;
endmodule

// File: rtl/uart_fc_chk.sv
module uart_fc_chk
  import uart_fc_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned SYNC_N = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [DIV_W-1:0]    baud_div_i,
  input logic                nine_bit_i,
  input logic [1:0]          parity_i,
  input logic                rts_en_i,
  input logic                cts_en_i,
  input logic [DATA_MAX-1:0] tx_data_i,
  input logic                tx_valid_i,
  input logic                tx_ready_o,
  input logic                txd_o,
  input logic                cts_ni,
  input logic                rxd_i,
  input logic [DATA_MAX-1:0] rx_data_o,
  input logic                rx_valid_o,
  input logic                rx_read_i,
  input logic                rx_perr_o,
  input logic                rx_ferr_o,
  input logic                rx_overrun_o,
  input logic                rts_no
);
  p_cts_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o && cts_en_i) |-> !$past(cts_ni, 2));

  p_start_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> (!txd_o && !tx_ready_o));

  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ready_o) |-> txd_o);

  p_hold_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_read_i) |=> (rx_valid_o && $stable(rx_data_o)));

  p_overrun_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_overrun_o |=> rx_overrun_o);
endmodule

bind uart_fc uart_fc_chk #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) chk_i (.*);

// File: tb/uart_fc_tb_top.sv
module uart_fc_tb_top;
  localparam int DIV = 1;
  localparam int P   = 16 * (DIV + 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] baud_div = 16'(DIV);
  logic       nine_bit = 1'b0;
  logic [1:0] parity = 2'd0;
  logic       rts_en = 1'b0;
  logic       cts_en = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       txd;
  logic       cts_n;
  logic       rxd;
  logic [8:0] rx_data;
  logic       rx_valid;
  logic       rx_read = 1'b0;
  logic       rx_perr, rx_ferr, rx_overrun;
  logic       rts_n;

  logic loop_rx = 1'b1;
  logic loop_cts = 1'b0;
  logic rxd_drv = 1'b1;
  logic cts_drv = 1'b0;

  assign rxd   = loop_rx ? txd : rxd_drv;
  assign cts_n = loop_cts ? rts_n : cts_drv;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  uart_fc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .baud_div_i(baud_div), .nine_bit_i(nine_bit),
    .parity_i(parity), .rts_en_i(rts_en), .cts_en_i(cts_en), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .txd_o(txd), .cts_ni(cts_n),
    .rxd_i(rxd), .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_read_i(rx_read),
    .rx_perr_o(rx_perr), .rx_ferr_o(rx_ferr), .rx_overrun_o(rx_overrun), .rts_no(rts_n)
  );

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  function automatic logic [8:0] mask_of(input logic nb);
    return nb ? 9'h1FF : 9'h0FF;
  endfunction

  task automatic exp_frame(input logic [8:0] d, input logic nb, input logic [1:0] pm,
                           output logic [11:0] bits, output int n);
    int nd;
    nd = nb ? 9 : 8;
    bits = '0;
    for (int i = 0; i < nd; i++) bits[1 + i] = d[i];
    n = 1 + nd;
    if (pm == 2'd1 || pm == 2'd2) begin
      bits[n] = (^(d & mask_of(nb))) ^ (pm == 2'd2);
      n++;
    end
    bits[n] = 1'b1;
    n++;
  endtask

  task automatic send(input logic [8:0] d);
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic capture(input int n, output logic [11:0] bits);
    bits = '0;
    while (txd) @(negedge clk);
    repeat (P / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      if (i != n - 1) repeat (P) @(negedge clk);
    end
  endtask

  task automatic pop();
    @(negedge clk);
    rx_read = 1'b1;
    @(negedge clk);
    rx_read = 1'b0;
  endtask

  task automatic loop_frame(input logic [8:0] d, input string tag);
    logic [11:0] eb, gb;
    int n;
    exp_frame(d, nine_bit, parity, eb, n);
    fork
      send(d);
      capture(n, gb);
    join
    chk(gb == eb, tag, 16'(gb), 16'(eb));
    if (parity == 2'd1 || parity == 2'd2)
      chk(gb[n-2] == eb[n-2], "R2", 16'(gb[n-2]), 16'(eb[n-2]));
    repeat (10) @(negedge clk);
    chk(rx_valid == 1'b1, "R5", 16'(rx_valid), 16'd1);
    chk(rx_data == (d & mask_of(nine_bit)), "R5", 16'(rx_data), 16'(d & mask_of(nine_bit)));
    chk(rx_perr == 1'b0, "R9", 16'(rx_perr), 16'd0);
    chk(rx_ferr == 1'b0, "R10", 16'(rx_ferr), 16'd0);
    pop();
    chk(rx_valid == 1'b0, "R6", 16'(rx_valid), 16'd0);
  endtask

  task automatic drive_raw(input logic [11:0] bits, input int n, input int last_len);
    for (int i = 0; i < n - 1; i++) begin
      rxd_drv = bits[i];
      repeat (P) @(negedge clk);
    end
    rxd_drv = bits[n-1];
    repeat (last_len) @(negedge clk);
    rxd_drv = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [11:0] eb, gb;
    int n;
    logic [8:0] seq [6];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(txd == 1'b1, "R1", 16'(txd), 16'd1);
    chk(tx_ready == 1'b1, "R3", 16'(tx_ready), 16'd1);
    chk(rx_valid == 1'b0, "R6", 16'(rx_valid), 16'd0);
    chk(rts_n == 1'b0, "R7", 16'(rts_n), 16'd0);
    chk(rx_overrun == 1'b0, "R8", 16'(rx_overrun), 16'd0);

    // R1/R2 sweep over data length, parity mode and data patterns
    for (int nb = 0; nb < 2; nb++) begin
      for (int pm = 0; pm < 4; pm++) begin
        nine_bit = nb[0];
        parity   = 2'(pm);
        for (int k = 0; k < 6; k++) begin
          logic [8:0] d;
          d = (k == 0) ? 9'h000 : (k == 1) ? 9'h1FF : 9'((k * 9'h04B) ^ 9'h0C3);
          loop_frame(d, "R1");
        end
      end
    end

    // R7: RTS follows occupancy
    nine_bit = 1'b0;
    parity   = 2'd0;
    rts_en   = 1'b1;
    fork
      send(9'h0A5);
      begin
        while (!rx_valid) @(negedge clk);
      end
    join
    chk(rts_n == 1'b1, "R7", 16'(rts_n), 16'd1);
    rts_en = 1'b0;
    @(negedge clk);
    chk(rts_n == 1'b0, "R7", 16'(rts_n), 16'd0);
    rts_en = 1'b1;
    @(negedge clk);
    chk(rts_n == 1'b1, "R7", 16'(rts_n), 16'd1);
    pop();
    chk(rts_n == 1'b0, "R7", 16'(rts_n), 16'd0);

    // R4: CTS stall, release, mid-frame deassertion
    rts_en  = 1'b0;
    cts_en  = 1'b1;
    cts_drv = 1'b1;
    repeat (4) @(negedge clk);
    tx_data  = 9'h03C;
    tx_valid = 1'b1;
    begin
      logic seen_low;
      seen_low = 1'b0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (!txd || tx_ready) seen_low = 1'b1;
      end
      chk(!seen_low, "R4", 16'(seen_low), 16'd0);
    end
    exp_frame(9'h03C, 1'b0, 2'd0, eb, n);
    cts_drv = 1'b0;
    fork
      begin
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
      end
      capture(n, gb);
      begin
        while (txd) @(negedge clk);
        repeat (3 * P) @(negedge clk);
        cts_drv = 1'b1;
      end
    join
    chk(gb == eb, "R4", 16'(gb), 16'(eb));
    repeat (10) @(negedge clk);
    chk(rx_data == 9'h03C, "R4", 16'(rx_data), 16'h03C);
    pop();
    // CTS ignored when disabled
    cts_en = 1'b0;
    loop_frame(9'h0C9, "R4");
    cts_drv = 1'b0;

    // R5: short low pulse is not a start bit
    loop_rx = 1'b0;
    rxd_drv = 1'b1;
    repeat (8) @(negedge clk);
    rxd_drv = 1'b0;
    repeat (4) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (14 * P) @(negedge clk);
    chk(rx_valid == 1'b0, "R5", 16'(rx_valid), 16'd0);

    // R9: wrong even parity bit
    parity = 2'd1;
    exp_frame(9'h035, 1'b0, 2'd1, eb, n);
    eb[9] = ~eb[9];
    drive_raw(eb, n, P);
    repeat (P) @(negedge clk);
    chk(rx_valid == 1'b1, "R9", 16'(rx_valid), 16'd1);
    chk(rx_data == 9'h035, "R9", 16'(rx_data), 16'h035);
    chk(rx_perr == 1'b1, "R9", 16'(rx_perr), 16'd1);
    pop();

    // R10: stop bit low
    parity = 2'd0;
    exp_frame(9'h05A, 1'b0, 2'd0, eb, n);
    eb[n-1] = 1'b0;
    drive_raw(eb, n, P / 2 + 8);
    repeat (P) @(negedge clk);
    chk(rx_valid == 1'b1, "R10", 16'(rx_valid), 16'd1);
    chk(rx_data == 9'h05A, "R10", 16'(rx_data), 16'h05A);
    chk(rx_ferr == 1'b1, "R10", 16'(rx_ferr), 16'd1);
    pop();
    repeat (14 * P) @(negedge clk);
    chk(rx_valid == 1'b0, "R10", 16'(rx_valid), 16'd0);

    // R11: loopback with both flow controls and a slow consumer
    loop_rx  = 1'b1;
    loop_cts = 1'b1;
    cts_en   = 1'b1;
    rts_en   = 1'b1;
    nine_bit = 1'b1;
    parity   = 2'd2;
    for (int k = 0; k < 6; k++) seq[k] = 9'((k * 9'h097) ^ 9'h12C);
    fork
      for (int k = 0; k < 6; k++) send(seq[k]);
      for (int k = 0; k < 6; k++) begin
        while (!rx_valid) @(negedge clk);
        repeat (1500) @(negedge clk);
        chk(rx_data == seq[k], "R11", 16'(rx_data), 16'(seq[k]));
        pop();
      end
    join
    chk(rx_overrun == 1'b0, "R11", 16'(rx_overrun), 16'd0);

    // R8: overrun drops the newer character
    loop_cts = 1'b0;
    cts_en   = 1'b0;
    rts_en   = 1'b0;
    nine_bit = 1'b0;
    parity   = 2'd0;
    send(9'h011);
    while (!rx_valid) @(negedge clk);
    send(9'h022);
    repeat (14 * P) @(negedge clk);
    chk(rx_overrun == 1'b1, "R8", 16'(rx_overrun), 16'd1);
    chk(rx_data == 9'h011, "R8", 16'(rx_data), 16'h011);
    pop();
    repeat (4) @(negedge clk);
    chk(rx_overrun == 1'b1, "R8", 16'(rx_overrun), 16'd1);
    chk(rx_valid == 1'b0, "R8", 16'(rx_valid), 16'd0);

    finish_run();
  end
endmodule